// File: doc/BRIEF.md
# STS-12 Receive Overhead Processor

This block sits behind a byte framer on one STS-12 receive stream. Every clock it takes one scrambled byte and a frame pulse that marks the first framing byte. From that pulse it keeps its own row and column counters, so it always knows which byte of the 9-row frame is passing. It then removes the line scrambling from every byte that was scrambled, and hands the result downstream one cycle later. The forwarded frame pulse and an even-parity bit travel with each byte.

The block also checks section parity. It folds every received byte of a frame, still scrambled, into an 8-bit running XOR. It compares that value with the descrambled parity byte at row 2, column 1 of the next frame. Each bit that differs adds one to a saturating error counter, which is visible on an output port.

Downstream equipment can be sent a line alarm: the whole output stream is replaced with all-ones bytes. This happens either on command, or, when enabled, for as long as the framer reports loss of frame alignment.

Top module: `sts12_rx_oh`

## Requirements
- R1: `dout`, `par_out` and `fp_out` are registered, one cycle after the input byte. `fp_out` is `fp_in` delayed by one cycle.
- R2: The byte with `fp_in`=1 is row 1, column 1. Positions then count across COLS columns and ROWS rows and wrap on their own. A later `fp_in` restarts the count at row 1, column 1.
- R3: Row 1, columns 1 to OH_COLS pass to `dout` unchanged. These are the framing, trace and growth bytes.
- R4: Every other byte is XORed with a key from the 1 + x^6 + x^7 generator.
  - The 7-bit state is set to all ones at row 1, column OH_COLS+1.
  - The key is the generator output, MSB first: out = s[6], then s <= {s[5:0], s[6]^s[5]}.
  - The first key byte is 0xFE.
  - The state advances only on descrambled positions.
- R5: With `descr_en`=0, every byte reaches `dout` unchanged.
- R6: Parity check and error count.
  - The parity value is the XOR of all raw input bytes from one frame start up to the next frame start.
  - At row 2, column 1, the descrambled byte is compared with the parity value of the previous frame.
  - `b1_err_cnt` grows by the number of differing bits.
  - No comparison is made until one whole frame has followed the first `fp_in`.
- R7: `b1_err_cnt` saturates at 2^CNT_W-1 and never decreases.
- R8: With `ais_force`=1, the byte in that cycle leaves as 0xFF.
- R9: With `ais_oof_en`=1 and `oof_in`=1, the byte leaves as 0xFF. `oof_in` has no effect while `ais_oof_en`=0.
- R10: `par_out` makes the number of ones in {`dout`,`par_out`} even.
- R11: After reset, `dout`=0, `par_out`=0, `fp_out`=0 and `b1_err_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Scrambled received byte |
| fp_in | input | 1 | Marks the first framing byte of a frame |
| oof_in | input | 1 | Framer reports out-of-frame |
| descr_en | input | 1 | Enables descrambling |
| ais_force | input | 1 | Forces the all-ones alarm onto the output |
| ais_oof_en | input | 1 | Enables the alarm while out-of-frame |
| dout | output | 8 | Descrambled byte |
| fp_out | output | 1 | Forwarded frame pulse |
| par_out | output | 1 | Even parity of `dout` |
| b1_err_cnt | output | CNT_W | Saturating parity bit-error count |

## Verification
The assertions check these properties on every cycle:
- the pulse delay;
- the alarm overrides, both forced and out-of-frame;
- the bypass of the fixed row-1 overhead bytes;
- the counter range of the position logic;
- that the error counter moves only at the parity byte, by at most eight, and never downward.

Some behaviours depend on whole frames of data, and only the bench's scenarios can show them:
- that the descrambling key and its reset point are correct;
- that the parity value really covers the previous frame's scrambled bytes;
- that the counter grows by exactly the number of corrupted bits and stops at its ceiling;
- that a mid-frame pulse restarts the position count.

// File: rtl/sts12_rx_oh_pkg.sv
package sts12_rx_oh_pkg;

  // Advance the 1 + x^6 + x^7 generator by eight outputs.
  // Result: {next_state[6:0], key_byte[7:0]}, key MSB first.
  function automatic logic [14:0] scr_advance(input logic [6:0] s_in);
    logic [6:0] s;
    logic [7:0] k;
    s = s_in;
    k = '0;
    for (int i = 0; i < 8; i++) begin
      k[7-i] = s[6];
      s      = {s[5:0], s[6] ^ s[5]};
    end
    return {s, k};
  endfunction

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/sts12_rx_oh_timing.sv
module sts12_rx_oh_timing #(
  parameter int COLS    = 1080,
  parameter int ROWS    = 9,
  parameter int OH_COLS = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_in,
  output logic frame_start,
  output logic fixed_oh,
  output logic scr_seed,
  output logic at_b1
);
  localparam int CW = $clog2(COLS);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] OH_C     = CW'(OH_COLS);

  logic [CW-1:0] col_q, col_d, cur_col;
  logic [RW-1:0] row_q, row_d, cur_row;

  always_comb begin
    cur_col = fp_in ? '0 : col_q;
    cur_row = fp_in ? '0 : row_q;
    if (cur_col == COL_LAST) begin
      col_d = '0;
      row_d = (cur_row == ROW_LAST) ? '0 : cur_row + 1'b1;
    end else begin
      col_d = cur_col + 1'b1;
      row_d = cur_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign frame_start = (cur_row == '0) && (cur_col == '0);
  assign fixed_oh    = (cur_row == '0) && (cur_col < OH_C);
  assign scr_seed    = (cur_row == '0) && (cur_col == OH_C);
  assign at_b1       = (cur_row == RW'(1)) && (cur_col == '0);

  p_col_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q <= COL_LAST) && (row_q <= ROW_LAST));
  p_fp_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fp_in |=> (col_q == CW'(1)) && (row_q == '0));

endmodule

// File: rtl/sts12_rx_oh_descr.sv
module sts12_rx_oh_descr
  import sts12_rx_oh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] raw,
  input  logic       bypass,
  input  logic       seed,
  input  logic       enable,
  output logic [7:0] plain
);
  logic [6:0]  st_q, st_d;
  logic [14:0] adv;

  always_comb begin
    adv  = scr_advance(seed ? 7'h7F : st_q);
    st_d = st_q;
    if (!bypass) st_d = adv[14:8];
    plain = (enable && !bypass) ? (raw ^ adv[7:0]) : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 7'h7F;
    else        st_q <= st_d;
  end

  p_state_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 7'h00);

endmodule

// File: rtl/sts12_rx_oh_bip.sv
module sts12_rx_oh_bip
  import sts12_rx_oh_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       raw,
  input  logic [7:0]       plain,
  input  logic             fp_in,
  input  logic             frame_start,
  input  logic             at_b1,
  output logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [7:0]       acc_q, acc_d, bip_q, bip_d;
  logic             seen_q, seen_d, valid_q, valid_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;
  logic             chk;

  always_comb begin
    acc_d   = frame_start ? raw : (acc_q ^ raw);
    bip_d   = frame_start ? acc_q : bip_q;
    valid_d = frame_start ? seen_q : valid_q;
    seen_d  = seen_q | fp_in;
    chk     = at_b1 && valid_q;
    sum     = {1'b0, cnt_q} + (CNT_W+1)'(ones8(plain ^ bip_q));
    cnt_d   = cnt_q;
    if (chk) cnt_d = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      bip_q   <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      acc_q   <= acc_d;
      bip_q   <= bip_d;
      seen_q  <= seen_d;
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
    end
  end

  assign err_cnt = cnt_q;

  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chk |=> $stable(cnt_q));
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk |=> ({1'b0, cnt_q} - {1'b0, $past(cnt_q)}) <= (CNT_W+1)'(8));
  p_cnt_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q >= $past(cnt_q));

endmodule

// File: rtl/sts12_rx_oh.sv
module sts12_rx_oh #(
  parameter int COLS    = 1080,
  parameter int ROWS    = 9,
  parameter int OH_COLS = 36,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       din,
  input  logic             fp_in,
  input  logic             oof_in,
  input  logic             descr_en,
  input  logic             ais_force,
  input  logic             ais_oof_en,
  output logic [7:0]       dout,
  output logic             fp_out,
  output logic             par_out,
  output logic [CNT_W-1:0] b1_err_cnt
);
  logic       rs_q1, rs_q2;
  logic       frame_start, fixed_oh, scr_seed, at_b1;
  logic [7:0] plain, dout_d, dout_q;
  logic       par_d, par_q, fp_q, ais_on;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  sts12_rx_oh_timing #(.COLS(COLS), .ROWS(ROWS), .OH_COLS(OH_COLS)) u_timing (
    .clk(clk), .rst_n(rs_q2), .fp_in(fp_in),
    .frame_start(frame_start), .fixed_oh(fixed_oh),
    .scr_seed(scr_seed), .at_b1(at_b1));

  sts12_rx_oh_descr u_descr (
    .clk(clk), .rst_n(rs_q2), .raw(din), .bypass(fixed_oh),
    .seed(scr_seed), .enable(descr_en), .plain(plain));

  sts12_rx_oh_bip #(.CNT_W(CNT_W)) u_bip (
    .clk(clk), .rst_n(rs_q2), .raw(din), .plain(plain), .fp_in(fp_in),
    .frame_start(frame_start), .at_b1(at_b1), .err_cnt(b1_err_cnt));

  always_comb begin
    ais_on = ais_force | (ais_oof_en & oof_in);
    dout_d = ais_on ? 8'hFF : plain;
    par_d  = ^dout_d;
  end

  always_ff @(posedge clk or negedge rs_q2) begin
    if (!rs_q2) begin
      dout_q <= '0;
      par_q  <= 1'b0;
      fp_q   <= 1'b0;
    end else begin
      dout_q <= dout_d;
      par_q  <= par_d;
      fp_q   <= fp_in;
    end
  end

  assign dout    = dout_q;
  assign par_out = par_q;
  assign fp_out  = fp_q;

  p_fp_fwd_r1: assert property (@(posedge clk) disable iff (!rs_q2)
    fp_in |=> fp_out);
  p_ais_force_r8: assert property (@(posedge clk) disable iff (!rs_q2)
    ais_force |=> (dout == 8'hFF) && !par_out);
  p_ais_oof_r9: assert property (@(posedge clk) disable iff (!rs_q2)
    (ais_oof_en && oof_in) |=> (dout == 8'hFF));
  p_oh_bypass_r3: assert property (@(posedge clk) disable iff (!rs_q2)
    (fixed_oh && !ais_force && !(ais_oof_en && oof_in)) |=> (dout == $past(din)));

endmodule

// File: tb/test_sts12_rx_oh.sv
module test_sts12_rx_oh;
  localparam int COLS  = 48;
  localparam int ROWS  = 9;
  localparam int OHC   = 36;
  localparam int CW    = 5;
  localparam int FRAME = COLS * ROWS;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    din;
  logic          fp_in, oof_in, descr_en, ais_force, ais_oof_en;
  logic [7:0]    dout;
  logic          fp_out, par_out;
  logic [CW-1:0] b1_err_cnt;

  always #5 clk = ~clk;

  sts12_rx_oh #(.COLS(COLS), .ROWS(ROWS), .OH_COLS(OHC), .CNT_W(CW)) i_sts12_rx_oh (
    .clk(clk), .rst_n(rst_n), .din(din), .fp_in(fp_in), .oof_in(oof_in),
    .descr_en(descr_en), .ais_force(ais_force), .ais_oof_en(ais_oof_en),
    .dout(dout), .fp_out(fp_out), .par_out(par_out), .b1_err_cnt(b1_err_cnt));

  int n_chk = 0, n_fail = 0;
  int pos = 0, exp_cnt = 0;
  logic [6:0] lf = 7'h7F;
  logic [7:0] acc = 8'h00, bipv = 8'h00;
  bit started = 0, valid = 0;
  bit c_descr = 1, c_force = 0, c_oof = 0, c_oofen = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (pos %0d)", tag, act, expv, pos);
    end
  endtask

  function automatic int bits8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  // One byte: model per the requirements, drive, then check one cycle later (R1).
  task automatic step(input logic [7:0] rd, input bit fp, input logic [7:0] mask);
    int row, col;
    bit fixed, ais;
    logic [7:0] key, raw, desc, expo;
    string tag;
    pos   = fp ? 0 : (pos + 1) % FRAME;          // R2
    row   = pos / COLS;
    col   = pos % COLS;
    fixed = (row == 0) && (col < OHC);
    key   = 8'h00;
    if (row == 0 && col == OHC) lf = 7'h7F;      // R4 seed
    if (!fixed)
      for (int i = 0; i < 8; i++) begin
        key[7-i] = lf[6];
        lf = {lf[5:0], lf[6] ^ lf[5]};
      end
    if (pos == 0) begin bipv = acc; valid = started; acc = 8'h00; end
    if (fp) started = 1;
    raw = rd;
    if (row == 1 && col == 0 && valid) raw = bipv ^ mask ^ (c_descr ? key : 8'h00);
    acc ^= raw;
    desc = (c_descr && !fixed) ? (raw ^ key) : raw;
    if (row == 1 && col == 0 && valid) begin
      exp_cnt += bits8(desc ^ bipv);
      if (exp_cnt > CMAX) exp_cnt = CMAX;
    end
    ais  = c_force || (c_oofen && c_oof);
    expo = ais ? 8'hFF : desc;
    if (c_force) tag = "R8";
    else if (ais) tag = "R9";
    else if (fixed) tag = "R3";
    else if (!c_descr) tag = "R5";
    else tag = "R4";
    @(negedge clk);
    din = raw; fp_in = fp; descr_en = c_descr; ais_force = c_force;
    oof_in = c_oof; ais_oof_en = c_oofen;
    @(posedge clk);
    #1;
    chk(tag, dout, expo);
    chk("R10", par_out, ^expo);
    chk("R1", fp_out, fp);
    chk(exp_cnt == CMAX ? "R7" : "R6", b1_err_cnt, exp_cnt);
  endtask

  // mode 0: clean, 1: random force, 2: random out-of-frame with random enable
  task automatic frame(input logic [7:0] mask, input int mode, input int len);
    for (int i = 0; i < len; i++) begin
      c_force = (mode == 1) && ($urandom % 5 == 0);
      c_oof   = (mode == 2) && ($urandom % 3 == 0);
      c_oofen = (mode == 2) && ($urandom % 2 == 0);
      step(8'($urandom), i == 0, mask);
    end
    c_force = 0; c_oof = 0; c_oofen = 0;
  endtask

  initial begin
    int seed;
    seed = $urandom(1234);
    rst_n = 1'b0; din = 8'h00; fp_in = 0; oof_in = 0;
    descr_en = 1; ais_force = 0; ais_oof_en = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", dout, 0); chk("R11", par_out, 0);
    chk("R11", fp_out, 0); chk("R11", b1_err_cnt, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    frame(8'h00, 0, FRAME);          // R2 first frame, no parity check yet
    frame(8'h00, 0, FRAME);          // R6 clean parity
    frame(8'h05, 0, FRAME);          // R6 two bit errors
    frame(8'hFF, 1, FRAME);          // R6 eight errors, R8 forced alarm
    c_descr = 0;
    frame(8'h01, 0, FRAME);          // R5 descrambler off
    c_descr = 1;
    frame(8'h00, 2, 200);            // R9 out-of-frame; R2 early restart
    frame(8'h80, 0, FRAME);          // parity over the partial frame
    frame(8'hFF, 0, FRAME);
    frame(8'hFF, 0, FRAME);
    frame(8'hFF, 0, FRAME);          // R7 saturation
    frame(8'h3C, 2, FRAME);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule